// File: doc/BRIEF.md
# Receive Packet Checksum Accumulator

This block sits in an Ethernet receive path and forms a 16-bit one's complement sum over each incoming frame while its bytes stream past, one byte per clock. The window to be summed opens at a programmable byte position. That position is measured on the frame as it looks once any VLAN tag is gone. Bytes flagged as tag bytes are dropped from both the sum and the position count. When the strip-CRC input is high, the four trailing CRC bytes are also left out. The finished sum is presented with a single-cycle done strobe. Software then corrects it for pseudo-header and excluded bytes before comparing it with a transport checksum.

A small 32-bit control word holds three things: the start position and two enable flags, one for IP header checksum offload and one for TCP/UDP checksum offload. Writes to it take effect only while the receiver is disabled. Each enable flag gates a pass/fail status input on its way to the output, so a disabled offload never reports a pass.

Top module: `rx_pkt_csum`

## Requirements
- R1: After reset the control word reads 0x00000000 and the done strobe is low.
- R2: A control write with `rx_enable` low stores bits 7:0 as the start position, bit 8 as the IP offload enable and bit 9 as the TCP/UDP offload enable; bits 31:10 always read as zero.
- R3: A control write made while `rx_enable` is high leaves the control word unchanged.
- R4: The sum covers frame bytes from the start position onward, where position 0 is the first byte. Bytes are paired in stream order into 16-bit words, the earlier byte being the high byte.
- R5: Words are added with end-around carry, so a carry out of bit 15 is added back into bit 0 (e.g. 0xFFFF + 0x0001 gives 0x0001).
- R6: An odd final byte in the window is summed as the high byte of a word whose low byte is zero.
- R7: Bytes marked with `in_tag` contribute nothing to the sum and do not advance the byte position.
- R8: With `strip_crc` high, the last four non-tag bytes of the frame are excluded from the sum.
- R9: If the frame holds no more non-tag bytes than the start position (after CRC exclusion), the sum is 0x0000.
- R10: `csum_done` is high for exactly the cycle after the cycle that accepts an end-of-frame byte, and `csum_out` holds that frame's sum in that cycle.
- R11: A new frame may start in the cycle right after an end-of-frame byte, and its sum does not depend on the previous frame.
- R12: `ip_ok_q` equals `ip_ok_in` AND the IP enable bit, and `l4_ok_q` equals `l4_ok_in` AND the TCP/UDP enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_enable | input | 1 | Receiver enabled; blocks control writes while high |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word write data |
| cfg_rd_data | output | 32 | Current control word |
| strip_crc | input | 1 | Exclude the trailing four CRC bytes from the sum |
| in_valid | input | 1 | Byte on `in_byte` is valid this cycle |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_tag | input | 1 | Byte belongs to a stripped VLAN tag |
| in_byte | input | 8 | Frame byte |
| ip_ok_in | input | 1 | IP checksum pass indication from the parser |
| l4_ok_in | input | 1 | TCP/UDP checksum pass indication from the parser |
| csum_out | output | 16 | Final folded frame sum |
| csum_done | output | 1 | One-cycle strobe: `csum_out` is valid |
| ip_ok_q | output | 1 | IP pass, gated by its enable |
| l4_ok_q | output | 1 | TCP/UDP pass, gated by its enable |

## Verification
The done strobe and result of one frame fall in the same cycle as the first byte of the next frame. In that cycle the accumulator has to publish the old sum and also start the new one from zero. The bench sends frames back to back with no idle cycle, and only now and then inserts a gap. It checks the strobe and the result in the cycle where the next frame's first byte is being driven. Each sum is compared with a value the bench works out from the frame bytes, the tag flags, the start position and the CRC setting. This covers lengths that leave the CRC hold-back register only part full when the frame ends.

// File: rtl/rx_csum_pkg.sv
package rx_csum_pkg;

   localparam int SUM_W  = 16;
   localparam int BYTE_W = 8;

   // one's complement addition with the carry wrapped back into bit 0
   function automatic logic [SUM_W-1:0] oc_add(input logic [SUM_W-1:0] a,
                                               input logic [SUM_W-1:0] b);
      logic [SUM_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[SUM_W-1:0] + {{(SUM_W-1){1'b0}}, s[SUM_W]};
   endfunction

endpackage

// File: rtl/rx_csum_cfg.sv
module rx_csum_cfg #(
   parameter int OFS_W = 8,
   parameter int CFG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_enable,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output logic [OFS_W-1:0] start_ofs,
   output logic             ip_en,
   output logic             l4_en,
   output logic [CFG_W-1:0] rd_data
);
   localparam int IP_BIT = OFS_W;
   localparam int L4_BIT = OFS_W + 1;
   localparam int USED_W = OFS_W + 2;

   generate
      if (CFG_W < USED_W) begin : g_bad_cfg_w
         $error("rx_csum_cfg: CFG_W too narrow for the fields");
      end
   endgenerate

   logic [USED_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_en && !rx_enable) begin
         cfg_q <= wr_data[USED_W-1:0];
      end
   end

   assign start_ofs = cfg_q[OFS_W-1:0];
   assign ip_en     = cfg_q[IP_BIT];
   assign l4_en     = cfg_q[L4_BIT];
   assign rd_data   = CFG_W'(cfg_q);

endmodule

// File: rtl/rx_csum_window.sv
module rx_csum_window #(
   parameter int OFS_W     = 8,
   parameter int CRC_BYTES = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             in_valid,
   input  logic                             in_sof,
   input  logic                             in_eof,
   input  logic                             in_tag,
   input  logic [rx_csum_pkg::BYTE_W-1:0]   in_byte,
   input  logic [OFS_W-1:0]                 start_ofs,
   input  logic                             strip_crc,
   output logic                             rel_valid,
   output logic [rx_csum_pkg::BYTE_W-1:0]   rel_byte,
   output logic                             frm_start,
   output logic                             frm_end
);
   import rx_csum_pkg::*;

   localparam int IDX_W = OFS_W + 1;

   logic [IDX_W-1:0] idx_q, idx_base, idx_d;
   logic             take, elig;

   assign frm_start = in_valid && in_sof;
   assign frm_end   = in_valid && in_eof;

   always_comb begin
      idx_base = in_sof ? '0 : idx_q;
      take     = in_valid && !in_tag;
      elig     = take && (idx_base >= {1'b0, start_ofs});
      idx_d    = idx_q;
      if (in_valid) begin
         idx_d = idx_base;
         if (take && !(&idx_base)) idx_d = idx_base + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q <= '0;
      else        idx_q <= idx_d;
   end

   generate
      if (CRC_BYTES == 0) begin : g_no_hold
         assign rel_valid = elig;
         assign rel_byte  = in_byte;
      end else begin : g_hold
         localparam int CNT_W = $clog2(CRC_BYTES + 1);

         logic [BYTE_W-1:0] hold_q [CRC_BYTES];
         logic [CNT_W-1:0]  occ_q, occ_base;
         logic              full;

         assign occ_base  = frm_start ? '0 : occ_q;
         assign full      = (occ_base == CNT_W'(CRC_BYTES));
         assign rel_valid = strip_crc ? (elig && full) : elig;
         assign rel_byte  = strip_crc ? hold_q[0] : in_byte;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               occ_q <= '0;
            end else if (in_valid) begin
               if (in_eof)                          occ_q <= '0;
               else if (elig && strip_crc && !full) occ_q <= occ_base + 1'b1;
               else                                 occ_q <= occ_base;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < CRC_BYTES; i++) hold_q[i] <= '0;
            end else if (elig && strip_crc) begin
               for (int i = 0; i < CRC_BYTES - 1; i++) hold_q[i] <= hold_q[i+1];
               hold_q[CRC_BYTES-1] <= in_byte;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rx_csum_accum.sv
module rx_csum_accum (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              rel_valid,
   input  logic [rx_csum_pkg::BYTE_W-1:0]    rel_byte,
   input  logic                              frm_start,
   input  logic                              frm_end,
   output logic [rx_csum_pkg::SUM_W-1:0]     sum_q,
   output logic                              done_q
);
   import rx_csum_pkg::*;

   logic [SUM_W-1:0]  acc_q, acc_b, acc_n, fin;
   logic [BYTE_W-1:0] hi_q, hi_n;
   logic              half_q, half_b, half_n;

   always_comb begin
      acc_b  = frm_start ? '0   : acc_q;
      half_b = frm_start ? 1'b0 : half_q;
      acc_n  = acc_b;
      half_n = half_b;
      hi_n   = hi_q;
      if (rel_valid) begin
         if (half_b) begin
            acc_n  = oc_add(acc_b, {hi_q, rel_byte});
            half_n = 1'b0;
         end else begin
            hi_n   = rel_byte;
            half_n = 1'b1;
         end
      end
      fin = half_n ? oc_add(acc_n, {hi_n, {BYTE_W{1'b0}}}) : acc_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         hi_q   <= '0;
         half_q <= 1'b0;
         sum_q  <= '0;
         done_q <= 1'b0;
      end else begin
         acc_q  <= acc_n;
         hi_q   <= hi_n;
         half_q <= half_n;
         done_q <= frm_end;
         if (frm_end) sum_q <= fin;
      end
   end

endmodule

// File: rtl/rx_pkt_csum.sv
module rx_pkt_csum #(
   parameter int OFS_W     = 8,
   parameter int CRC_BYTES = 4,
   parameter int CFG_W     = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_enable,
   input  logic             cfg_wr_en,
   input  logic [CFG_W-1:0] cfg_wr_data,
   output logic [CFG_W-1:0] cfg_rd_data,
   input  logic             strip_crc,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic             in_tag,
   input  logic [7:0]       in_byte,
   input  logic             ip_ok_in,
   input  logic             l4_ok_in,
   output logic [15:0]      csum_out,
   output logic             csum_done,
   output logic             ip_ok_q,
   output logic             l4_ok_q
);
   import rx_csum_pkg::*;

   generate
      if (OFS_W < 1 || OFS_W > 16) begin : g_bad_ofs_w
         $error("rx_pkt_csum: OFS_W out of range");
      end
      if (CRC_BYTES < 0 || CRC_BYTES > 16) begin : g_bad_crc
         $error("rx_pkt_csum: CRC_BYTES out of range");
      end
   endgenerate

   logic [OFS_W-1:0]  start_ofs;
   logic              ip_en, l4_en;
   logic              rel_valid, frm_start, frm_end;
   logic [BYTE_W-1:0] rel_byte;

   rx_csum_cfg #(.OFS_W(OFS_W), .CFG_W(CFG_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_enable (rx_enable),
      .wr_en     (cfg_wr_en),
      .wr_data   (cfg_wr_data),
      .start_ofs (start_ofs),
      .ip_en     (ip_en),
      .l4_en     (l4_en),
      .rd_data   (cfg_rd_data)
   );

   rx_csum_window #(.OFS_W(OFS_W), .CRC_BYTES(CRC_BYTES)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sof    (in_sof),
      .in_eof    (in_eof),
      .in_tag    (in_tag),
      .in_byte   (in_byte),
      .start_ofs (start_ofs),
      .strip_crc (strip_crc),
      .rel_valid (rel_valid),
      .rel_byte  (rel_byte),
      .frm_start (frm_start),
      .frm_end   (frm_end)
   );

   rx_csum_accum u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .rel_valid (rel_valid),
      .rel_byte  (rel_byte),
      .frm_start (frm_start),
      .frm_end   (frm_end),
      .sum_q     (csum_out),
      .done_q    (csum_done)
   );

   assign ip_ok_q = ip_ok_in && ip_en;
   assign l4_ok_q = l4_ok_in && l4_en;

endmodule

// File: rtl/rx_pkt_csum_chk.sv
module rx_pkt_csum_chk #(
   parameter int OFS_W = 8,
   parameter int CFG_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_enable,
   input logic             cfg_wr_en,
   input logic [CFG_W-1:0] cfg_wr_data,
   input logic [CFG_W-1:0] cfg_rd_data,
   input logic             in_valid,
   input logic             in_eof,
   input logic             csum_done,
   input logic             ip_ok_q,
   input logic             l4_ok_q
);
   localparam int USED_W = OFS_W + 2;

   // R2
   cfg_write_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && !rx_enable) |=> (cfg_rd_data[USED_W-1:0] == $past(cfg_wr_data[USED_W-1:0])));

   // R2
   cfg_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_data >> USED_W) == '0);

   // R3
   cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && rx_enable) |=> $stable(cfg_rd_data));

   // R10
   done_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof) |=> csum_done);

   // R10
   done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csum_done |-> $past(in_valid && in_eof));

   // R12
   ip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd_data[OFS_W] |-> !ip_ok_q);

   // R12
   l4_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd_data[OFS_W+1] |-> !l4_ok_q);

endmodule

bind rx_pkt_csum rx_pkt_csum_chk #(.OFS_W(OFS_W), .CFG_W(CFG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_enable   (rx_enable),
   .cfg_wr_en   (cfg_wr_en),
   .cfg_wr_data (cfg_wr_data),
   .cfg_rd_data (cfg_rd_data),
   .in_valid    (in_valid),
   .in_eof      (in_eof),
   .csum_done   (csum_done),
   .ip_ok_q     (ip_ok_q),
   .l4_ok_q     (l4_ok_q)
);

// File: tb/rx_pkt_csum_tb.sv
`timescale 1ns/1ps
module rx_pkt_csum_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        rx_enable, cfg_wr_en, strip_crc;
   logic [31:0] cfg_wr_data, cfg_rd_data;
   logic        in_valid, in_sof, in_eof, in_tag;
   logic [7:0]  in_byte;
   logic        ip_ok_in, l4_ok_in, ip_ok_q, l4_ok_q;
   logic [15:0] csum_out;
   logic        csum_done;

   always #2 clk = ~clk;

   rx_pkt_csum u_dut (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
      .strip_crc(strip_crc), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
      .in_tag(in_tag), .in_byte(in_byte), .ip_ok_in(ip_ok_in), .l4_ok_in(l4_ok_in),
      .csum_out(csum_out), .csum_done(csum_done), .ip_ok_q(ip_ok_q), .l4_ok_q(l4_ok_q)
   );

   int          n_chk = 0;
   int          n_fail = 0;
   bit          exp_pend = 0;
   logic [15:0] exp_sum;
   string       exp_req;
   logic [7:0]  fb [0:63];
   bit          ft [0:63];
   int          flen;
   int          cur_ofs;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // advance to the falling edge and judge the done strobe there
   task automatic tick();
      @(negedge clk);
      if (exp_pend) begin
         chk(csum_done === 1'b1, "R10", {31'd0, csum_done}, 32'd1);
         chk(csum_out === exp_sum, exp_req, {16'd0, csum_out}, {16'd0, exp_sum});
         exp_pend = 0;
      end else begin
         chk(csum_done === 1'b0, "R10", {31'd0, csum_done}, 32'd0);
      end
   endtask

   task automatic idle();
      tick();
      in_valid = 0; in_sof = 0; in_eof = 0; in_tag = 0;
   endtask

   task automatic wr_cfg(input logic [31:0] d, input bit en);
      tick();
      in_valid = 0; in_sof = 0; in_eof = 0;
      rx_enable = en; cfg_wr_en = 1; cfg_wr_data = d;
      tick();
      cfg_wr_en = 0; rx_enable = 1;
   endtask

   function automatic logic [15:0] ref_sum(input int ofs, input bit strip);
      logic [7:0] nb [0:63];
      int n = 0;
      int acc = 0;
      for (int i = 0; i < flen; i++) if (!ft[i]) begin nb[n] = fb[i]; n++; end
      if (strip) n = (n >= 4) ? n - 4 : 0;
      for (int i = ofs; i < n; i += 2) begin
         int w;
         w = nb[i] * 256 + ((i + 1 < n) ? int'(nb[i+1]) : 0);
         acc = acc + w;
         if (acc > 65535) acc = acc - 65535;
      end
      return acc[15:0];
   endfunction

   function automatic int nontag_count();
      int n = 0;
      for (int i = 0; i < flen; i++) if (!ft[i]) n++;
      return n;
   endfunction

   task automatic send_frame(input string req);
      logic [15:0] s;
      s = ref_sum(cur_ofs, strip_crc);
      for (int i = 0; i < flen; i++) begin
         tick();
         in_valid = 1; in_sof = (i == 0); in_eof = (i == flen - 1);
         in_tag = ft[i]; in_byte = fb[i];
      end
      exp_sum = s; exp_req = req; exp_pend = 1;
   endtask

   initial begin
      rst_n = 0; rx_enable = 0; cfg_wr_en = 0; cfg_wr_data = 0; strip_crc = 0;
      in_valid = 0; in_sof = 0; in_eof = 0; in_tag = 0; in_byte = 0;
      ip_ok_in = 0; l4_ok_in = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cfg_rd_data === 32'h0, "R1", cfg_rd_data, 32'h0);
      chk(csum_done === 1'b0, "R1", {31'd0, csum_done}, 32'd0);
      rst_n = 1;

      // R2 writable fields, reserved bits read zero
      wr_cfg(32'hFFFF_FFFF, 0);
      chk(cfg_rd_data === 32'h0000_03FF, "R2", cfg_rd_data, 32'h3FF);
      wr_cfg(32'h0000_0155, 0);
      chk(cfg_rd_data === 32'h0000_0155, "R2", cfg_rd_data, 32'h155);
      // R3 write while receiving is dropped
      wr_cfg(32'h0000_02AA, 1);
      chk(cfg_rd_data === 32'h0000_0155, "R3", cfg_rd_data, 32'h155);

      // R12 enable gating of both pass indications
      for (int en = 0; en < 4; en++) begin
         wr_cfg({22'd0, en[1:0], 8'd0}, 0);
         for (int v = 0; v < 4; v++) begin
            tick();
            ip_ok_in = v[0]; l4_ok_in = v[1];
            #1;
            chk(ip_ok_q === (v[0] & en[0]), "R12", {31'd0, ip_ok_q}, {31'd0, v[0] & en[0]});
            chk(l4_ok_q === (v[1] & en[1]), "R12", {31'd0, l4_ok_q}, {31'd0, v[1] & en[1]});
         end
      end

      // R5 end-around carry: FFFF + 0001 -> 0001
      cur_ofs = 0; strip_crc = 0; flen = 4;
      fb[0] = 8'hFF; fb[1] = 8'hFF; fb[2] = 8'h00; fb[3] = 8'h01;
      for (int i = 0; i < 4; i++) ft[i] = 0;
      send_frame("R5");
      idle();

      // sweep: offsets, lengths, CRC strip, tag insertion
      for (int st = 0; st < 2; st++) begin
         for (int oi = 0; oi < 6; oi++) begin
            int ofs_tab [6] = '{0, 1, 2, 3, 5, 14};
            cur_ofs = ofs_tab[oi];
            wr_cfg(cur_ofs, 0);
            strip_crc = st[0];
            for (int tg = 0; tg < 2; tg++) begin
               for (int len = 1; len <= 22; len++) begin
                  string req;
                  int nt;
                  flen = len;
                  for (int i = 0; i < len; i++) begin
                     ft[i] = (tg == 1) && (len >= 18) && (i >= 12) && (i < 16);
                     fb[i] = ((len + cur_ofs) % 2 == 1) ? 8'(8'hF0 + i)
                                                        : 8'(i * 37 + len * 11 + 5);
                  end
                  nt = nontag_count();
                  if (st == 1) nt = (nt >= 4) ? nt - 4 : 0;
                  if (nt <= cur_ofs)                  req = "R9";
                  else if (st == 1)                   req = "R8";
                  else if (tg == 1 && len >= 18)      req = "R7";
                  else if (((nt - cur_ofs) % 2) == 1) req = "R6";
                  else if (len % 4 == 0)              req = "R11";
                  else                                req = "R4";
                  send_frame(req);
                  if (len % 3 == 0) idle();
               end
            end
            idle();
         end
      end
      idle();
      idle();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule